// File: doc/BRIEF.md
# PSRAM Sleep-Mode Sequencer

This block sits between a host and a self-refreshing pseudo-static RAM. It drives the memory's active-low sleep pin, `zzN`. The host raises `sleepReq` to ask for low power and lowers it to ask for service again. The controller then picks one of two sleep flavours from the memory's sleep-select configuration bit, mirrored on `parMode`. With the bit set, the memory keeps refreshing part of its array, and it leaves that state the moment the pin rises. With the bit clear, the memory powers down completely and needs a long initialization after the pin rises before it can be used.

The controller holds the sleep pin low for a guaranteed minimum time. After a deep power-down it holds the memory unavailable for the full initialization window. Both times are counted in clock cycles, and the counts are derived from the clock frequency parameter. While the memory cannot be used, host accesses are not forwarded. They are held back and reported as stalled until the path opens.

Software can also write the configuration register. The controller learns of such a write through a one-cycle strobe and records it until the next reset. Once that record is set, the sleep pin can no longer start refresh-only sleep, so a sleep request made while `parMode` is 1 is refused.

Top module: `psramSleepTop`

## Requirements
- R1: While reset is active and after it is released, `zzN`=1, `ready`=1, `busy`=0, `sleepPar`=0 and `sleepDeep`=0.
- R2: An accepted sleep request drives `zzN` low with `busy`=1 and `ready`=0 for exactly LOW_CYCLES clock cycles, where LOW_CYCLES = ceil(CLK_FREQ_KHZ*MIN_LOW_NS/1e6)+1.
- R3: The mode entered after the low-time window is refresh-only sleep (`sleepPar`=1) if `parMode` was 1 in the cycle the request was accepted, and deep power-down (`sleepDeep`=1) if it was 0. Changes on `parMode` during the window have no effect.
- R4: In refresh-only sleep, dropping `sleepReq` gives `zzN`=1 and `ready`=1 on the next cycle, with no wait.
- R5: In deep power-down, dropping `sleepReq` raises `zzN` and keeps `busy`=1, `ready`=0 for exactly WAKE_CYCLES = ceil(CLK_FREQ_KHZ*WAKE_NS/1e6) cycles. After that, `ready`=1.
- R6: `memReq` equals `hostReq` only while `ready`=1, and is 0 otherwise. While it is 0, a pending request shows `hostStall`=1. `memWrite` equals `hostWrite` gated by `memReq`. A request held through sleep is forwarded once `ready` returns.
- R7: After a `softCfgDone` pulse, a sleep request while `parMode`=1 is refused: `ready` stays 1, `zzN` stays 1 and `busy` stays 0. The record is cleared only by reset.
- R8: After a `softCfgDone` pulse, a sleep request while `parMode`=0 still enters deep power-down through the pin, with the timing of R2 and R5.
- R9: Exactly one of `ready`, `busy`, `sleepPar` and `sleepDeep` is 1 in every cycle, and `ready`=1 implies `zzN`=1.
- R10: Once accepted, the low-time window always runs to completion, even if `sleepReq` drops during it. The chosen mode is then entered for one cycle before its exit follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset (power-up) |
| sleepReq | input | 1 | Host level: 1 asks for sleep, 0 asks for service |
| parMode | input | 1 | Mirror of the sleep-select configuration bit (1 refresh-only, 0 deep) |
| softCfgDone | input | 1 | One-cycle strobe: configuration written by software access |
| hostReq | input | 1 | Host access request |
| hostWrite | input | 1 | Host access is a write |
| zzN | output | 1 | Active-low sleep pin to the memory |
| ready | output | 1 | Memory available for access |
| busy | output | 1 | Entry window or wake initialization in progress |
| sleepPar | output | 1 | Memory in refresh-only sleep |
| sleepDeep | output | 1 | Memory in deep power-down |
| memReq | output | 1 | Access forwarded to the memory |
| memWrite | output | 1 | Forwarded access is a write |
| hostStall | output | 1 | Host request is being held back |

## Verification
The hardest case to reach from the ports is the one where the mode choice and the exit path cross: `parMode` toggles, or `sleepReq` falls, while the low-time window is still counting. The design must keep the mode latched at acceptance and still finish the window. The bench sweeps every combination of mode, mid-window mode flip and early request drop, and counts the window and wake cycles at the pins. It then issues a software-access strobe to show that refresh-only sleep is refused while deep power-down still works, and resets to show that the record clears.

// File: rtl/psramSleepPkg.sv
package psramSleepPkg;

  typedef enum logic [2:0] {
    ST_ACTIVE,
    ST_ENTERING,
    ST_PAR,
    ST_DPD,
    ST_WAKE_INIT
  } sleepState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadLow;   // start the minimum-low window
    logic loadWake;  // start the wake initialization window
    logic countEn;   // decrement the window counter
    logic pathOpen;  // memory access path may be used
  } timerStrobe_t;

endpackage

// File: rtl/psramSleepCtrl.sv
module psramSleepCtrl
  import psramSleepPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sleepReq,
  input  logic         parMode,
  input  logic         swSeen,
  input  logic         timerDone,
  output timerStrobe_t strobe,
  output sleepState_t  state
);

  sleepState_t nextState;
  logic        targetPar;

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_ACTIVE: begin
        strobe.pathOpen = 1'b1;
        // after software access, the pin can no longer start refresh-only sleep
        if (sleepReq && !(swSeen && parMode)) begin
          nextState      = ST_ENTERING;
          strobe.loadLow = 1'b1;
        end
      end
      ST_ENTERING: begin
        strobe.countEn = 1'b1;
        if (timerDone) nextState = targetPar ? ST_PAR : ST_DPD;
      end
      ST_PAR: begin
        if (!sleepReq) nextState = ST_ACTIVE;
      end
      ST_DPD: begin
        if (!sleepReq) begin
          nextState       = ST_WAKE_INIT;
          strobe.loadWake = 1'b1;
        end
      end
      ST_WAKE_INIT: begin
        strobe.countEn = 1'b1;
        if (timerDone) nextState = ST_ACTIVE;
      end
      default: nextState = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_ACTIVE;
      targetPar <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.loadLow) targetPar <= parMode;
    end
  end

endmodule

// File: rtl/psramSleepDatapath.sv
module psramSleepDatapath
  import psramSleepPkg::*;
#(
  parameter int unsigned LOW_CYCLES  = 11,
  parameter int unsigned WAKE_CYCLES = 150
) (
  input  logic         clk,
  input  logic         rstN,
  input  timerStrobe_t strobe,
  input  logic         softCfgDone,
  input  logic         hostReq,
  input  logic         hostWrite,
  output logic         timerDone,
  output logic         swSeen,
  output logic         memReq,
  output logic         memWrite,
  output logic         hostStall
);

  localparam int unsigned MAX_CYCLES = (LOW_CYCLES > WAKE_CYCLES) ? LOW_CYCLES : WAKE_CYCLES;
  localparam int CNT_W = $clog2(MAX_CYCLES + 1);

  logic [CNT_W-1:0] windowCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      windowCnt <= '0;
    end else if (strobe.loadLow) begin
      windowCnt <= CNT_W'(LOW_CYCLES - 1);
    end else if (strobe.loadWake) begin
      windowCnt <= CNT_W'(WAKE_CYCLES - 1);
    end else if (strobe.countEn && windowCnt != '0) begin
      windowCnt <= windowCnt - 1'b1;
    end
  end

  assign timerDone = (windowCnt == '0);

  // sticky record of a software-access configuration write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            swSeen <= 1'b0;
    else if (softCfgDone) swSeen <= 1'b1;
  end

  assign memReq    = hostReq & strobe.pathOpen;
  assign memWrite  = memReq & hostWrite;
  assign hostStall = hostReq & ~strobe.pathOpen;

endmodule

// File: rtl/psramSleepTop.sv
module psramSleepTop
  import psramSleepPkg::*;
#(
  parameter int unsigned CLK_FREQ_KHZ = 100000,
  parameter int unsigned MIN_LOW_NS   = 10000,
  parameter int unsigned WAKE_NS      = 150000
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic parMode,
  input  logic softCfgDone,
  input  logic hostReq,
  input  logic hostWrite,
  output logic zzN,
  output logic ready,
  output logic busy,
  output logic sleepPar,
  output logic sleepDeep,
  output logic memReq,
  output logic memWrite,
  output logic hostStall
);

  localparam longint unsigned FREQ64   = 64'(CLK_FREQ_KHZ);
  localparam longint unsigned LOW64    = (FREQ64 * 64'(MIN_LOW_NS) + 64'd999999) / 64'd1000000;
  localparam longint unsigned WAKE64   = (FREQ64 * 64'(WAKE_NS) + 64'd999999) / 64'd1000000;
  // strictly longer than the minimum: one extra cycle
  localparam int unsigned LOW_CYCLES  = 32'(LOW64 + 64'd1);
  localparam int unsigned WAKE_CYCLES = (WAKE64 == 64'd0) ? 1 : 32'(WAKE64);

  timerStrobe_t strobe;
  sleepState_t  state;
  logic         timerDone;
  logic         swSeen;

  psramSleepCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sleepReq  (sleepReq),
    .parMode   (parMode),
    .swSeen    (swSeen),
    .timerDone (timerDone),
    .strobe    (strobe),
    .state     (state)
  );

  psramSleepDatapath #(
    .LOW_CYCLES  (LOW_CYCLES),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .softCfgDone (softCfgDone),
    .hostReq     (hostReq),
    .hostWrite   (hostWrite),
    .timerDone   (timerDone),
    .swSeen      (swSeen),
    .memReq      (memReq),
    .memWrite    (memWrite),
    .hostStall   (hostStall)
  );

  assign ready     = (state == ST_ACTIVE);
  assign busy      = (state == ST_ENTERING) || (state == ST_WAKE_INIT);
  assign sleepPar  = (state == ST_PAR);
  assign sleepDeep = (state == ST_DPD);
  assign zzN       = (state == ST_ACTIVE) || (state == ST_WAKE_INIT);

endmodule

// File: rtl/psramSleepChecker.sv
module psramSleepChecker (
  input logic clk,
  input logic rstN,
  input logic sleepReq,
  input logic parMode,
  input logic hostReq,
  input logic zzN,
  input logic ready,
  input logic busy,
  input logic sleepPar,
  input logic sleepDeep,
  input logic memReq,
  input logic hostStall,
  input logic swSeen
);

  assert_one_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({ready, busy, sleepPar, sleepDeep}) == 1);

  assert_ready_pin_high_R9: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> zzN);

  assert_enter_window_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && sleepReq && !(swSeen && parMode)) |=> (busy && !zzN));

  assert_par_exit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (sleepPar && !sleepReq) |=> (ready && zzN));

  assert_deep_exit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (sleepDeep && !sleepReq) |=> (busy && zzN));

  assert_gate_closed_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostReq && !ready) |-> (!memReq && hostStall));

  assert_gate_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (ready && hostReq));

  assert_refuse_par_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ready && sleepReq && parMode && swSeen) |=> ready);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    swSeen |=> swSeen);

endmodule

bind psramSleepTop psramSleepChecker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .sleepReq  (sleepReq),
  .parMode   (parMode),
  .hostReq   (hostReq),
  .zzN       (zzN),
  .ready     (ready),
  .busy      (busy),
  .sleepPar  (sleepPar),
  .sleepDeep (sleepDeep),
  .memReq    (memReq),
  .hostStall (hostStall),
  .swSeen    (swSeen)
);

// File: tb/psramSleepTop_bench.sv
module psramSleepTop_bench;

  localparam int CLK_PERIOD = 10;
  localparam int FREQ_KHZ   = 1000;
  localparam int EXP_LOW    = (FREQ_KHZ * 10000 + 999999) / 1000000 + 1;
  localparam int EXP_WAKE   = (FREQ_KHZ * 150000 + 999999) / 1000000;

  logic clk = 1'b0;
  logic rstN, sleepReq, parMode, softCfgDone, hostReq, hostWrite;
  logic zzN, ready, busy, sleepPar, sleepDeep, memReq, memWrite, hostStall;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  psramSleepTop #(.CLK_FREQ_KHZ(FREQ_KHZ)) u_psramSleepTop (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .parMode(parMode),
    .softCfgDone(softCfgDone), .hostReq(hostReq), .hostWrite(hostWrite),
    .zzN(zzN), .ready(ready), .busy(busy), .sleepPar(sleepPar),
    .sleepDeep(sleepDeep), .memReq(memReq), .memWrite(memWrite),
    .hostStall(hostStall)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // full sleep cycle; modeTag names the requirement for the mode check
  task automatic runSleep(input bit par, input bit flipMid, input bit dropEarly, input string modeTag);
    int n;
    parMode  = par;
    sleepReq = 1'b1;
    hostReq  = 1'b1;
    hostWrite = 1'b1;
    tick();
    n = 0;
    while (busy && !zzN && n < 5000) begin
      n++;
      if (n == 1) chk(!memReq && hostStall, "R6 held during entry", {memReq, hostStall}, 1);
      if (flipMid && n == 2) parMode = !par;          // R3: ignored mid-window
      if (dropEarly && n == 3) sleepReq = 1'b0;       // R10: window still completes
      tick();
    end
    chk(n == EXP_LOW, dropEarly ? "R10 window length" : "R2 window length", n, EXP_LOW);
    chk(sleepPar == par && sleepDeep == !par, modeTag, {sleepPar, sleepDeep}, {par, !par});
    chk(!memReq && hostStall && !zzN, "R6 held in sleep", {memReq, hostStall, zzN}, 3'b010);
    if (!dropEarly) begin
      repeat (3) tick();
      chk(sleepPar == par && sleepDeep == !par, "R3 mode holds", {sleepPar, sleepDeep}, {par, !par});
      sleepReq = 1'b0;
    end
    tick();
    if (par) begin
      chk(ready && zzN, "R4 immediate exit", {ready, zzN}, 3);
      chk(memReq && memWrite && !hostStall, "R6 forwarded after sleep", {memReq, memWrite, hostStall}, 6);
    end else begin
      n = 0;
      while (busy && zzN && n < 5000) begin
        n++;
        if (n == 1) chk(!memReq && hostStall, "R6 held during wake", {memReq, hostStall}, 1);
        tick();
      end
      chk(n == EXP_WAKE, "R5 wake length", n, EXP_WAKE);
      chk(ready && zzN && memReq, "R5 ready after wake", {ready, zzN, memReq}, 7);
    end
    hostReq   = 1'b0;
    hostWrite = 1'b0;
    parMode   = par;
    tick();
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    rstN = 1'b0; sleepReq = 1'b0; parMode = 1'b0; softCfgDone = 1'b0;
    hostReq = 1'b0; hostWrite = 1'b0;
    repeat (2) tick();
    chk(zzN && ready && !busy && !sleepPar && !sleepDeep, "R1 during reset",
        {zzN, ready, busy, sleepPar, sleepDeep}, 5'b11000);
    rstN = 1'b1;
    tick();
    chk(zzN && ready && !busy && !sleepPar && !sleepDeep, "R1 after reset",
        {zzN, ready, busy, sleepPar, sleepDeep}, 5'b11000);

    // R6: gating in the active state, all request/write combinations
    for (int c = 0; c < 4; c++) begin
      hostReq = c[0]; hostWrite = c[1];
      tick();
      chk(memReq == c[0] && memWrite == (c[0] & c[1]) && !hostStall, "R6 active pass-through",
          {memReq, memWrite, hostStall}, {c[0], c[0] & c[1], 1'b0});
    end
    hostReq = 1'b0; hostWrite = 1'b0;
    tick();

    // R3 / R4 / R5 / R10 sweep over mode, mid-window flip and early drop
    for (int p = 0; p < 2; p++)
      for (int f = 0; f < 2; f++)
        for (int d = 0; d < 2; d++)
          runSleep(p[0], f[0], d[0], "R3 mode choice");

    // R7: software access recorded, refresh-only sleep refused
    softCfgDone = 1'b1;
    tick();
    softCfgDone = 1'b0;
    parMode = 1'b1;
    sleepReq = 1'b1;
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(ready && zzN && !busy, "R7 refused", {ready, zzN, busy}, 6);
    end
    sleepReq = 1'b0;
    tick();

    // R8: deep power-down still reachable through the pin
    runSleep(1'b0, 1'b0, 1'b0, "R8 deep after software access");

    // R7: record persists, then clears only by reset
    parMode = 1'b1;
    sleepReq = 1'b1;
    tick(); tick();
    chk(ready && zzN, "R7 still refused", {ready, zzN}, 3);
    sleepReq = 1'b0;
    rstN = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
    chk(ready && zzN && !busy, "R1 after second reset", {ready, zzN, busy}, 6);
    runSleep(1'b1, 1'b0, 1'b0, "R7 cleared by reset");

    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (R1..all) actual=timeout expected=completion");
    finishRun();
  end

endmodule